// File: doc/BRIEF.md
# Programmable I/O Chip Select Decoder

This block drives three independent active-low chip select lines for an ISA-style I/O bus. Each channel holds a 16-bit base address and an 8-bit control byte. When the bus is not in a DMA cycle (AEN low) and every compared address bit equals the stored base, the channel may assert its select. The control byte decides two things. It can drop A0, A1, A2 or A3 from the compare one bit at a time, or drop the whole A11–A0 field. It also chooses whether the select follows the read strobe, the write strobe, both, or neither.

Software reaches the nine configuration bytes through two index registers. A first-level index must hold the bank code `BANK_CODE` (a parameter) before any chip-select register can be reached. A second-level index then picks one byte inside the bank. A data port writes or reads that byte. The select outputs are purely combinational from the bus pins. The register file changes only on the rising clock edge.

Top module: `iocs_decoder`

## Requirements
- R1: A synchronous active-high reset clears all nine configuration bytes to 00h, and every channel's select output then stays high (inactive).
- R2: With the bank code selected, the second-level index picks a byte as follows. For channel c in 0..2, index 4c+0 holds base A15–A8, index 4c+1 holds base A7–A0 and index 4c+2 holds the control byte. A data write becomes visible at the read port after the next rising edge.
- R3: Second-level indices 03h, 07h and 0Bh–FFh reach no register. A write there leaves all nine bytes unchanged, and a read there returns 00h.
- R4: While the first-level index differs from `BANK_CODE`, data writes change nothing and reads return 00h.
- R5: While AEN is high, no select output is asserted.
- R6: With no mask bits set, a channel matches only when all 16 address bits equal its base. The high base byte is compared with A15–A8 and the low base byte with A7–A0.
- R7: Control bits 0, 1, 2 and 3, when set, each remove A0, A1, A2 or A3 respectively from the compare.
- R8: Control bit 7, when set, removes all of A11–A0 from the compare.
- R9: Control bit 4 lets a match assert the select while WR# is low. Control bit 5 lets a match assert it while RD# is low. With bits 4, 5 and 6 clear, the select never asserts.
- R10: Control bit 6, when set, asserts the select on any match whatever the state of RD# and WR#, and bits 4 and 5 then have no effect.
- R11: A select output follows changes on the address, AEN and strobe pins within the same clock cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_idx_we | input | 1 | Load the first-level index |
| bank_idx_wdata | input | 8 | First-level index value |
| sub_idx_we | input | 1 | Load the second-level index |
| sub_idx_wdata | input | 8 | Second-level index value |
| data_we | input | 1 | Write the selected configuration byte |
| data_wdata | input | 8 | Configuration write data |
| data_rdata | output | 8 | Selected configuration byte, 00h when unreachable |
| bus_addr | input | 16 | I/O bus address A15–A0 |
| bus_aen | input | 1 | Address enable, high during DMA cycles |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| cs_n | output | 3 | Chip select per channel, active low |

## Verification
Some properties are checked on every cycle. An AEN-high cycle keeps all selects idle. A channel with bit 6 clear stays idle while both strobes are high. Writes while a foreign bank is selected, or aimed at an unreachable index, leave the register file unchanged. A reset leaves the file cleared. Other behaviours show only in the bench's scenarios: the exact index map, the per-bit and whole-field masking, read versus write qualification, and the override of bit 6. The bench reaches them by programming bases and control bytes, then driving addresses that differ from the base in chosen bit positions.

// File: rtl/iocs_pkg.sv
package iocs_pkg;

    localparam int unsigned CS_CHANNELS = 3;
    localparam int unsigned ADDR_W      = 16;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned LOW_MASK_W  = 4;
    localparam int unsigned FIELD_W     = 12;

    // Control byte layout; bit positions are behaviour (software writes them).
    typedef struct packed {
        logic                  skip_low12;   // bit 7
        logic                  any_cycle;    // bit 6
        logic                  on_read;      // bit 5
        logic                  on_write;     // bit 4
        logic [LOW_MASK_W-1:0] skip_bit;     // bits 3..0
    } cs_ctrl_t;

    typedef enum logic [1:0] {
        SLOT_HI   = 2'd0,
        SLOT_LO   = 2'd1,
        SLOT_CTRL = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] chan;
        slot_e      slot;
    } reg_sel_t;

    function automatic reg_sel_t decode_index(input logic [BYTE_W-1:0] idx);
        reg_sel_t s;
        s.chan = idx[3:2];
        s.slot = slot_e'(idx[1:0]);
        s.hit  = (idx[7:4] == 4'h0) &&
                 (idx[1:0] != 2'd3) &&
                 (32'(idx[3:2]) < CS_CHANNELS);
        return s;
    endfunction

    // Bit set = address bit takes part in the compare.
    function automatic logic [ADDR_W-1:0] compare_mask(input cs_ctrl_t c);
        logic [ADDR_W-1:0] m;
        m = '1;
        if (c.skip_low12) m[FIELD_W-1:0] = '0;
        m[LOW_MASK_W-1:0] = m[LOW_MASK_W-1:0] & ~c.skip_bit;
        return m;
    endfunction

    function automatic logic strobe_ok(input cs_ctrl_t c,
                                       input logic rd_n,
                                       input logic wr_n);
        return c.any_cycle || (c.on_read && !rd_n) || (c.on_write && !wr_n);
    endfunction

endpackage

// File: rtl/iocs_index_regs.sv
module iocs_index_regs
    import iocs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] BANK_CODE = 8'h2C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_we,
    input  logic [BYTE_W-1:0] bank_wdata,
    input  logic              sub_we,
    input  logic [BYTE_W-1:0] sub_wdata,
    output logic [BYTE_W-1:0] bank_q,
    output logic              bank_open,
    output reg_sel_t          sel
);
    logic [BYTE_W-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            sub_q  <= '0;
        end else begin
            if (bank_we) bank_q <= bank_wdata;
            if (sub_we)  sub_q  <= sub_wdata;
        end
    end

    always_comb begin
        bank_open = (bank_q == BANK_CODE);
        sel       = decode_index(sub_q);
    end
endmodule

// File: rtl/iocs_cfg_regs.sv
module iocs_cfg_regs
    import iocs_pkg::*;
#(
    parameter int unsigned NCH = CS_CHANNELS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_open,
    input  reg_sel_t          sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] base_o [NCH],
    output cs_ctrl_t          ctrl_o [NCH]
);
    localparam int unsigned HALF_W = ADDR_W / 2;

    logic access_ok;
    assign access_ok = bank_open && sel.hit;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [HALF_W-1:0] hi_q;
        logic [HALF_W-1:0] lo_q;
        cs_ctrl_t          ctl_q;
        logic              mine;

        assign mine = access_ok && wr_en && (sel.chan == 2'(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q  <= '0;
                lo_q  <= '0;
                ctl_q <= '0;
            end else if (mine) begin
                case (sel.slot)
                    SLOT_HI:   hi_q  <= wdata;
                    SLOT_LO:   lo_q  <= wdata;
                    SLOT_CTRL: ctl_q <= cs_ctrl_t'(wdata);
                    default:   ;
                endcase
            end
        end

        assign base_o[ch] = {hi_q, lo_q};
        assign ctrl_o[ch] = ctl_q;
    end

    always_comb begin
        rdata = '0;
        if (access_ok) begin
            for (int ch = 0; ch < int'(NCH); ch++) begin
                if (sel.chan == 2'(ch)) begin
                    case (sel.slot)
                        SLOT_HI:   rdata = base_o[ch][ADDR_W-1:HALF_W];
                        SLOT_LO:   rdata = base_o[ch][HALF_W-1:0];
                        SLOT_CTRL: rdata = ctrl_o[ch];
                        default:   rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/iocs_chan_match.sv
module iocs_chan_match
    import iocs_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  cs_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              aen,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              sel_n
);
    logic [ADDR_W-1:0] diff;
    logic              addr_hit;
    logic              qual;

    always_comb begin
        diff     = (addr ^ base) & compare_mask(ctrl);
        addr_hit = !aen && (diff == '0);
        qual     = strobe_ok(ctrl, rd_n, wr_n);
        sel_n    = !(addr_hit && qual);
    end
endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
    import iocs_pkg::*;
#(
    parameter logic [7:0] BANK_CODE = 8'h2C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bank_idx_we,
    input  logic [7:0]  bank_idx_wdata,
    input  logic        sub_idx_we,
    input  logic [7:0]  sub_idx_wdata,
    input  logic        data_we,
    input  logic [7:0]  data_wdata,
    output logic [7:0]  data_rdata,
    input  logic [15:0] bus_addr,
    input  logic        bus_aen,
    input  logic        bus_rd_n,
    input  logic        bus_wr_n,
    output logic [2:0]  cs_n
);
    localparam int unsigned NCH = CS_CHANNELS;

    logic [BYTE_W-1:0] bank_q;
    logic              bank_open;
    reg_sel_t          sel;
    logic [ADDR_W-1:0] base_w [NCH];
    cs_ctrl_t          ctrl_w [NCH];

    // Flattened state, observed by the bound checker.
    logic [NCH*BYTE_W-1:0]       ctrl_flat;
    logic [NCH*(ADDR_W+BYTE_W)-1:0] state_flat;

    iocs_index_regs #(.BANK_CODE(BANK_CODE)) idx_i (
        .clk        (clk),
        .rst        (rst),
        .bank_we    (bank_idx_we),
        .bank_wdata (bank_idx_wdata),
        .sub_we     (sub_idx_we),
        .sub_wdata  (sub_idx_wdata),
        .bank_q     (bank_q),
        .bank_open  (bank_open),
        .sel        (sel)
    );

    iocs_cfg_regs #(.NCH(NCH)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bank_open (bank_open),
        .sel       (sel),
        .wr_en     (data_we),
        .wdata     (data_wdata),
        .rdata     (data_rdata),
        .base_o    (base_w),
        .ctrl_o    (ctrl_w)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_match
        iocs_chan_match match_i (
            .base  (base_w[ch]),
            .ctrl  (ctrl_w[ch]),
            .addr  (bus_addr),
            .aen   (bus_aen),
            .rd_n  (bus_rd_n),
            .wr_n  (bus_wr_n),
            .sel_n (cs_n[ch])
        );
        assign ctrl_flat[ch*BYTE_W +: BYTE_W] = ctrl_w[ch];
        assign state_flat[ch*(ADDR_W+BYTE_W) +: (ADDR_W+BYTE_W)] = {base_w[ch], ctrl_w[ch]};
    end
endmodule

// File: rtl/iocs_decoder_chk.sv
module iocs_decoder_chk #(
    parameter logic [7:0]  BANK_CODE = 8'h2C,
    parameter int unsigned NCH       = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_aen,
    input logic               bus_rd_n,
    input logic               bus_wr_n,
    input logic [NCH-1:0]     cs_n,
    input logic [7:0]         bank_q,
    input logic               sub_hit,
    input logic               data_we,
    input logic [NCH*8-1:0]   ctrl_flat,
    input logic [NCH*24-1:0]  state_flat
);
    // R1: one cycle after a reset cycle, the register file is clear
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (state_flat == '0));

    // R5: AEN high keeps every select idle
    a_r5_aen_idle: assert property (@(posedge clk) disable iff (rst)
        bus_aen |-> (cs_n == '1));

    // R4: data writes with a foreign bank leave the file unchanged
    a_r4_bank_guard: assert property (@(posedge clk) disable iff (rst)
        (data_we && (bank_q != BANK_CODE)) |=> $stable(state_flat));

    // R3: data writes to an unreachable index leave the file unchanged
    a_r3_reserved_guard: assert property (@(posedge clk) disable iff (rst)
        (data_we && !sub_hit) |=> $stable(state_flat));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        // R9: without the override bit, no strobe means no select
        a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
            (bus_rd_n && bus_wr_n && !ctrl_flat[ch*8+6]) |-> cs_n[ch]);
    end
endmodule

bind iocs_decoder iocs_decoder_chk #(.BANK_CODE(BANK_CODE), .NCH(3)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_aen    (bus_aen),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .cs_n       (cs_n),
    .bank_q     (bank_q),
    .sub_hit    (sel.hit),
    .data_we    (data_we),
    .ctrl_flat  (ctrl_flat),
    .state_flat (state_flat)
);

// File: tb/iocs_decoder_tb.sv
module iocs_decoder_tb_top;
    localparam logic [7:0] BANK = 8'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_idx_we = 1'b0;
    logic [7:0]  bank_idx_wdata = '0;
    logic        sub_idx_we = 1'b0;
    logic [7:0]  sub_idx_wdata = '0;
    logic        data_we = 1'b0;
    logic [7:0]  data_wdata = '0;
    logic [7:0]  data_rdata;
    logic [15:0] bus_addr = '0;
    logic        bus_aen = 1'b0;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [2:0]  cs_n;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          finished = 1'b0;
    logic [7:0]  mdl [16];
    logic [7:0]  cur_bank = '0;

    always #2 clk = ~clk;

    iocs_decoder #(.BANK_CODE(BANK)) dut_i (
        .clk(clk), .rst(rst),
        .bank_idx_we(bank_idx_we), .bank_idx_wdata(bank_idx_wdata),
        .sub_idx_we(sub_idx_we), .sub_idx_wdata(sub_idx_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .bus_addr(bus_addr), .bus_aen(bus_aen), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .cs_n(cs_n)
    );

    function automatic bit idx_valid(input logic [7:0] idx);
        return (idx < 8'h0B) && (idx[1:0] != 2'd3);
    endfunction

    function automatic logic exp_sel_n(input int ch, input logic [15:0] a,
                                       input logic aen, input logic rd_n, input logic wr_n);
        logic [15:0] base, m;
        logic [7:0]  c;
        logic        q;
        base = {mdl[ch*4], mdl[ch*4+1]};
        c    = mdl[ch*4+2];
        m    = 16'hFFFF;
        if (c[7]) m[11:0] = '0;
        m[3:0] = m[3:0] & ~c[3:0];
        q = c[6] || (c[5] && !rd_n) || (c[4] && !wr_n);
        return !(!aen && (((a ^ base) & m) == 16'h0) && q);
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic set_bank(input logic [7:0] v);
        @(negedge clk); bank_idx_we = 1'b1; bank_idx_wdata = v;
        @(negedge clk); bank_idx_we = 1'b0;
        cur_bank = v;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
        @(negedge clk); sub_idx_we = 1'b1; sub_idx_wdata = idx;
        @(negedge clk); sub_idx_we = 1'b0; data_we = 1'b1; data_wdata = v;
        @(negedge clk); data_we = 1'b0;
        if (cur_bank == BANK && idx_valid(idx)) mdl[idx[3:0]] = v;
    endtask

    task automatic reg_read(input string tag, input logic [7:0] idx, input logic [7:0] exp);
        @(negedge clk); sub_idx_we = 1'b1; sub_idx_wdata = idx;
        @(negedge clk); sub_idx_we = 1'b0;
        #1 check8(tag, data_rdata, exp);
    endtask

    task automatic bus_check(input string tag, input logic [15:0] a, input logic aen,
                             input logic rd_n, input logic wr_n);
        logic [2:0] exp;
        @(negedge clk);
        bus_addr = a; bus_aen = aen; bus_rd_n = rd_n; bus_wr_n = wr_n;
        #1;
        for (int ch = 0; ch < 3; ch++) exp[ch] = exp_sel_n(ch, a, aen, rd_n, wr_n);
        n_checks++;
        if (cs_n !== exp) begin
            n_errors++;
            $display("FAIL %s: cs_n got %03b expected %03b (addr %04h)", tag, cs_n, exp, a);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd7301));
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        set_bank(BANK);
        for (int i = 0; i < 11; i++)
            if (idx_valid(8'(i))) reg_read("R1 reset value", 8'(i), 8'h00);
        bus_check("R1 idle after reset", 16'h0000, 1'b0, 1'b0, 1'b0);
        bus_check("R1 idle after reset", 16'h03F8, 1'b0, 1'b1, 1'b0);

        // R2: index map
        for (int i = 0; i < 11; i++)
            if (idx_valid(8'(i))) reg_write(8'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 11; i++)
            if (idx_valid(8'(i))) reg_read("R2 readback", 8'(i), mdl[i]);

        // R3: reserved indices
        reg_write(8'h03, 8'hA5); reg_write(8'h07, 8'h5A);
        reg_write(8'h0B, 8'hFF); reg_write(8'h0F, 8'hC3);
        reg_write(8'h10, 8'h3C); reg_write(8'hFF, 8'h99);
        reg_read("R3 reserved read", 8'h07, 8'h00);
        reg_read("R3 reserved read", 8'h0C, 8'h00);
        reg_read("R3 reserved read", 8'h40, 8'h00);
        for (int i = 0; i < 11; i++)
            if (idx_valid(8'(i))) reg_read("R3 file untouched", 8'(i), mdl[i]);

        // R4: foreign bank
        set_bank(8'h2D);
        reg_write(8'h00, 8'hEE);
        reg_read("R4 foreign read", 8'h00, 8'h00);
        set_bank(BANK);
        reg_read("R4 file untouched", 8'h00, mdl[0]);

        // Directed decode on channel 0, base 0x0378
        reg_write(8'h00, 8'h03); reg_write(8'h01, 8'h78);
        reg_write(8'h04, 8'h00); reg_write(8'h05, 8'h00); reg_write(8'h06, 8'h00);
        reg_write(8'h08, 8'h00); reg_write(8'h09, 8'h00); reg_write(8'h0A, 8'h00);
        reg_write(8'h02, 8'h00);
        bus_check("R9 disabled channel", 16'h0378, 1'b0, 1'b0, 1'b0);
        reg_write(8'h02, 8'h20);
        bus_check("R9 read strobe", 16'h0378, 1'b0, 1'b0, 1'b1);
        bus_check("R9 write ignored", 16'h0378, 1'b0, 1'b1, 1'b0);
        reg_write(8'h02, 8'h10);
        bus_check("R9 write strobe", 16'h0378, 1'b0, 1'b1, 1'b0);
        bus_check("R9 read ignored", 16'h0378, 1'b0, 1'b0, 1'b1);
        bus_check("R5 aen blocks", 16'h0378, 1'b1, 1'b1, 1'b0);
        reg_write(8'h02, 8'h40);
        bus_check("R10 override", 16'h0378, 1'b0, 1'b1, 1'b1);
        reg_write(8'h02, 8'h70);
        bus_check("R10 override with bits 4/5", 16'h0378, 1'b0, 1'b0, 1'b1);
        bus_check("R6 A15 differs", 16'h8378, 1'b0, 1'b1, 1'b1);
        bus_check("R6 A0 differs", 16'h0379, 1'b0, 1'b1, 1'b1);
        reg_write(8'h02, 8'h45);
        bus_check("R7 A0 masked", 16'h0379, 1'b0, 1'b1, 1'b1);
        bus_check("R7 A2 masked", 16'h037C, 1'b0, 1'b1, 1'b1);
        bus_check("R7 A1 compared", 16'h037A, 1'b0, 1'b1, 1'b1);
        bus_check("R7 A4 compared", 16'h0368, 1'b0, 1'b1, 1'b1);
        reg_write(8'h02, 8'hC0);
        bus_check("R8 A11 masked", 16'h0B78, 1'b0, 1'b1, 1'b1);
        bus_check("R8 low field masked", 16'h0000, 1'b0, 1'b1, 1'b1);
        bus_check("R8 A12 compared", 16'h1378, 1'b0, 1'b1, 1'b1);

        // R11: select follows pins within one cycle
        @(negedge clk);
        bus_addr = 16'h0378; bus_aen = 1'b0;
        #1 begin
            n_checks++;
            if (cs_n[0] !== 1'b0) begin
                n_errors++;
                $display("FAIL R11 combinational assert: got %b expected 0", cs_n[0]);
            end
        end
        bus_aen = 1'b1;
        #0.5 begin
            n_checks++;
            if (cs_n[0] !== 1'b1) begin
                n_errors++;
                $display("FAIL R11 combinational release: got %b expected 1", cs_n[0]);
            end
        end

        // Constrained random: program channels, probe near the base (R6-R10)
        for (int it = 0; it < 200; it++) begin
            int ch;
            logic [15:0] a;
            ch = int'($urandom_range(2, 0));
            reg_write(8'(ch * 4),     8'($urandom));
            reg_write(8'(ch * 4 + 1), 8'($urandom));
            reg_write(8'(ch * 4 + 2), 8'($urandom));
            for (int k = 0; k < 6; k++) begin
                a = {mdl[ch*4], mdl[ch*4+1]};
                if ($urandom_range(1, 0) == 1) a = a ^ (16'h1 << $urandom_range(15, 0));
                bus_check("R6 random decode", a, ($urandom_range(7, 0) == 0),
                          1'($urandom), 1'($urandom));
            end
        end

        summary();
    end
endmodule